// File: doc/BRIEF.md
# DMA Transfer-Queue and Interrupt Controller

This block is the control and status slice of one DMA channel. Software reaches it through a plain 32-bit register bus with word addresses. Writes take effect on the clock edge and reads are combinational. The block holds the channel's enable, pause and cyclic settings. It turns a write to the submit register into a transfer request for the transfer engine. It gives every queued transfer a rotating 2-bit ID and keeps one completion bit per ID.

The engine answers with two single-cycle pulses. `eng_accept` means the requested descriptor was taken into the queue. `eng_complete` means the oldest outstanding transfer finished, either normally or with an error. From these pulses the block keeps the next-ID and active-ID counters, the done bitmap, and two interrupt sources: "queued" (bit 0) and "completed" (bit 1). Each source has a raw bit, a mask bit and a pending bit, and the single `irq` output is raised from the pending bits.

Register word addresses: 0 identification, 1 scratch, 4 interrupt mask, 5 interrupt pending, 6 interrupt source, 8 control (bit 0 enable, bit 1 pause), 9 next ID, 10 submit (bit 0), 11 flags (bit 0 cyclic), 12 done bitmap (bit n for ID n), 13 active ID.

Top module: `dqc_top`

## Requirements
- R1: After reset the interrupt mask reads 3, and pending, source, control, submit, flags, done bitmap, next ID, active ID and scratch all read 0; `irq` and `xfer_req` are low.
- R2: Address 0 always reads 0x444D4143 and ignores writes; address 1 is a fully writable 32-bit scratch register; any other unmapped address reads 0.
- R3: A source bit (bit 0 queued, bit 1 completed) is set by its event whatever the mask, and clears only when a 1 is written to the same bit of the pending register; if an event and such a write happen in one cycle, the bit stays set.
- R4: A pending bit is set by its event only while the matching mask bit is 0. Writing 1 clears it, writing 0 leaves it unchanged, and an event in the same cycle as the clear wins.
- R5: `irq` is high exactly when at least one pending bit is set.
- R6: Writing 1 to submit bit 0 while enabled makes submit read 1 until the engine accepts the transfer. A 0 write, or any write while disabled, has no effect. `xfer_req` is high when submit is 1, the channel is enabled and fewer than 4 transfers are outstanding. An `eng_accept` pulse while `xfer_req` is low is ignored.
- R7: The next-ID register starts at 0, advances by one on each accepted transfer and wraps from 3 to 0; `xfer_id` carries it.
- R8: The active-ID register advances by one on each counted completion. It therefore equals the next ID whenever no transfer is outstanding. A completion pulse is counted only while enabled, with at least one transfer outstanding, and with cyclic clear.
- R9: Done bit n is cleared when a transfer with ID n is accepted and set when that transfer's completion is counted.
- R10: While the cyclic flag is 1, completion pulses change nothing: no completed source or pending bit, no done bit and no active-ID step.
- R11: While enable is 0, submit, the done bitmap and the outstanding count are cleared, and the active ID is set equal to the next ID.
- R12: At most 4 transfers are outstanding. With 4 outstanding, `xfer_req` stays low and submit stays 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 4 | Write word address |
| wr_data | input | 32 | Write data |
| rd_addr | input | 4 | Read word address |
| rd_data | output | 32 | Combinational read data |
| eng_accept | input | 1 | Engine took the requested descriptor |
| eng_complete | input | 1 | Oldest outstanding transfer finished |
| xfer_req | output | 1 | A descriptor is offered to the engine |
| xfer_id | output | 2 | ID the offered descriptor will carry |
| chan_enable | output | 1 | Channel enable |
| chan_pause | output | 1 | Channel pause |
| chan_cyclic | output | 1 | Cyclic mode |
| irq | output | 1 | Interrupt request |

## Verification
The bench goes after the same-cycle collisions. A W1C write that lands with a new event must leave the bit set; a design that let the clear win would lose an interrupt. It fills the queue to four outstanding transfers and lets the IDs wrap, where a design without the cap would reuse an ID still in flight and corrupt the done bitmap. It also sends stray accept and complete pulses while nothing is offered or outstanding, during cyclic mode and while disabled. A design that counted these would drift its active ID away from the next ID or raise completion interrupts that should never appear.

// File: rtl/dqc_pkg.sv
// Shared constants of the DMA transfer-queue controller: register word
// addresses, the identification value and interrupt source bit positions.
package dqc_pkg;
    localparam int A_IDENT     = 0;
    localparam int A_SCRATCH   = 1;
    localparam int A_IRQ_MASK  = 4;
    localparam int A_IRQ_PEND  = 5;
    localparam int A_IRQ_SRC   = 6;
    localparam int A_CONTROL   = 8;
    localparam int A_NEXT_ID   = 9;
    localparam int A_SUBMIT    = 10;
    localparam int A_FLAGS     = 11;
    localparam int A_DONE      = 12;
    localparam int A_ACTIVE_ID = 13;

    localparam logic [31:0] IDENT_VALUE = 32'h444D_4143;

    localparam int NUM_SRC    = 2;
    localparam int SRC_QUEUED = 0;
    localparam int SRC_DONE   = 1;
endpackage

// File: rtl/dqc_regs.sv
// Software-written settings: scratch, interrupt mask, control, flags and the
// self-clearing submit bit.
// Assumes: one write per cycle, word addresses; accepted is a one-cycle pulse
// produced only while submit is 1.
module dqc_regs #(
    parameter int ADDR_W = 4,
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              accepted,
    output logic [DATA_W-1:0] scratch,
    output logic [dqc_pkg::NUM_SRC-1:0] irq_mask,
    output logic              enable,
    output logic              pause,
    output logic              cyclic,
    output logic              submit
);
    import dqc_pkg::*;

    function automatic logic hit(input int a);
        return wr_en && (wr_addr == ADDR_W'(a));
    endfunction

    // Plain read/write settings.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            scratch  <= '0;
            irq_mask <= '1;
            enable   <= 1'b0;
            pause    <= 1'b0;
            cyclic   <= 1'b0;
        end else begin
            if (hit(A_SCRATCH))  scratch  <= wr_data;
            if (hit(A_IRQ_MASK)) irq_mask <= wr_data[NUM_SRC-1:0];
            if (hit(A_CONTROL)) begin
                enable <= wr_data[0];
                pause  <= wr_data[1];
            end
            if (hit(A_FLAGS))    cyclic   <= wr_data[0];
        end
    end

    // Submit: set by a write of 1 while enabled, dropped on accept or disable.
    always_ff @(posedge clk) begin
        if (!rst_n)                              submit <= 1'b0;
        else if (!enable)                        submit <= 1'b0;
        else if (accepted)                       submit <= 1'b0;
        else if (hit(A_SUBMIT) && wr_data[0])    submit <= 1'b1;
    end
endmodule

// File: rtl/dqc_irq.sv
// Interrupt sources: one raw-source bit and one pending bit per source.
// Raw bits follow events regardless of mask; pending bits only when unmasked.
// Both clear on a write of 1 to the pending bit; a same-cycle event wins.
module dqc_irq #(
    parameter int NSRC = 2
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [NSRC-1:0] event_in,
    input  logic [NSRC-1:0] mask,
    input  logic            clr_wr,
    input  logic [NSRC-1:0] clr_bits,
    output logic [NSRC-1:0] pend,
    output logic [NSRC-1:0] src,
    output logic            irq
);
    for (genvar k = 0; k < NSRC; k++) begin : g_src
        // Raw source and pending flag of source k.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                src[k]  <= 1'b0;
                pend[k] <= 1'b0;
            end else begin
                if (event_in[k])                 src[k] <= 1'b1;
                else if (clr_wr && clr_bits[k])  src[k] <= 1'b0;
                if (event_in[k] && !mask[k])     pend[k] <= 1'b1;
                else if (clr_wr && clr_bits[k])  pend[k] <= 1'b0;
            end
        end
    end

    // Interrupt line from any pending source.
    always_comb irq = |pend;
endmodule

// File: rtl/dqc_idtrack.sv
// Transfer-ID bookkeeping: next ID, active ID, outstanding count and the
// per-ID done bitmap. Assumes transfers complete in the order they queued.
module dqc_idtrack #(
    parameter int ID_W = 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               enable,
    input  logic               queued,
    input  logic               completed,
    output logic [ID_W-1:0]    next_id,
    output logic [ID_W-1:0]    active_id,
    output logic [(1<<ID_W)-1:0] done_map,
    output logic               busy,
    output logic               full
);
    localparam int NUM_IDS = 1 << ID_W;
    localparam int CNT_W   = ID_W + 1;

    logic [CNT_W-1:0]   outst;
    logic [NUM_IDS-1:0] done_nxt;

    // Done bitmap after this cycle's events.
    always_comb begin
        done_nxt = done_map;
        if (completed) done_nxt[active_id] = 1'b1;
        if (queued)    done_nxt[next_id]   = 1'b0;
    end

    // Counters, bitmap and the disable flush.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            next_id   <= '0;
            active_id <= '0;
            outst     <= '0;
            done_map  <= '0;
        end else if (!enable) begin
            active_id <= next_id;
            outst     <= '0;
            done_map  <= '0;
        end else begin
            if (queued)    next_id   <= next_id + 1'b1;
            if (completed) active_id <= active_id + 1'b1;
            outst    <= outst + CNT_W'(queued) - CNT_W'(completed);
            done_map <= done_nxt;
        end
    end

    // Queue occupancy flags.
    always_comb begin
        busy = (outst != '0);
        full = (outst == CNT_W'(NUM_IDS));
    end
endmodule

// File: rtl/dqc_top.sv
// DMA transfer-queue and interrupt controller top: register decode and read
// mux, event qualification from the engine pulses, and the three sub-blocks.
// Assumes engine pulses are one cycle wide and completions arrive in order.
module dqc_top #(
    parameter int ADDR_W = 4,
    parameter int DATA_W = 32,
    parameter int ID_W   = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [DATA_W-1:0] rd_data,
    input  logic              eng_accept,
    input  logic              eng_complete,
    output logic              xfer_req,
    output logic [ID_W-1:0]   xfer_id,
    output logic              chan_enable,
    output logic              chan_pause,
    output logic              chan_cyclic,
    output logic              irq
);
    import dqc_pkg::*;
    localparam int NUM_IDS = 1 << ID_W;

    logic [DATA_W-1:0]  scratch_q;
    logic [NUM_SRC-1:0] irq_mask_q, irq_pend_q, irq_src_q, irq_event;
    logic               ctl_enable, ctl_pause, ctl_cyclic, submit_q;
    logic [ID_W-1:0]    next_id_q, active_id_q;
    logic [NUM_IDS-1:0] done_map_q;
    logic               q_busy, q_full, ev_queued, ev_completed;

    // Qualify engine pulses into counted events.
    always_comb begin
        xfer_req     = submit_q && ctl_enable && !q_full;
        ev_queued    = eng_accept && xfer_req;
        ev_completed = eng_complete && ctl_enable && q_busy && !ctl_cyclic;
        irq_event    = '0;
        irq_event[SRC_QUEUED] = ev_queued;
        irq_event[SRC_DONE]   = ev_completed;
    end

    dqc_regs #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_regs (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .accepted(ev_queued), .scratch(scratch_q),
        .irq_mask(irq_mask_q), .enable(ctl_enable), .pause(ctl_pause),
        .cyclic(ctl_cyclic), .submit(submit_q)
    );

    dqc_irq #(.NSRC(NUM_SRC)) u_irq (
        .clk(clk), .rst_n(rst_n), .event_in(irq_event), .mask(irq_mask_q),
        .clr_wr(wr_en && (wr_addr == ADDR_W'(A_IRQ_PEND))),
        .clr_bits(wr_data[NUM_SRC-1:0]), .pend(irq_pend_q), .src(irq_src_q),
        .irq(irq)
    );

    dqc_idtrack #(.ID_W(ID_W)) u_ids (
        .clk(clk), .rst_n(rst_n), .enable(ctl_enable), .queued(ev_queued),
        .completed(ev_completed), .next_id(next_id_q), .active_id(active_id_q),
        .done_map(done_map_q), .busy(q_busy), .full(q_full)
    );

    // Combinational register read mux.
    always_comb begin
        rd_data = '0;
        case (rd_addr)
            ADDR_W'(A_IDENT):     rd_data = DATA_W'(IDENT_VALUE);
            ADDR_W'(A_SCRATCH):   rd_data = scratch_q;
            ADDR_W'(A_IRQ_MASK):  rd_data = DATA_W'(irq_mask_q);
            ADDR_W'(A_IRQ_PEND):  rd_data = DATA_W'(irq_pend_q);
            ADDR_W'(A_IRQ_SRC):   rd_data = DATA_W'(irq_src_q);
            ADDR_W'(A_CONTROL):   rd_data = DATA_W'({ctl_pause, ctl_enable});
            ADDR_W'(A_NEXT_ID):   rd_data = DATA_W'(next_id_q);
            ADDR_W'(A_SUBMIT):    rd_data = DATA_W'(submit_q);
            ADDR_W'(A_FLAGS):     rd_data = DATA_W'(ctl_cyclic);
            ADDR_W'(A_DONE):      rd_data = DATA_W'(done_map_q);
            ADDR_W'(A_ACTIVE_ID): rd_data = DATA_W'(active_id_q);
            default:              rd_data = '0;
        endcase
    end

    // Channel outputs.
    always_comb begin
        xfer_id     = next_id_q;
        chan_enable = ctl_enable;
        chan_pause  = ctl_pause;
        chan_cyclic = ctl_cyclic;
    end
endmodule

// File: rtl/dqc_checker.sv
// Temporal checks on the controller, bound into every dqc_top instance.
module dqc_checker #(
    parameter int ID_W = 2
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 wr_en,
    input logic                 eng_accept,
    input logic                 xfer_req,
    input logic                 enable,
    input logic                 submit,
    input logic                 cyclic,
    input logic [1:0]           mask,
    input logic [1:0]           pend,
    input logic [1:0]           src,
    input logic [ID_W-1:0]      next_id,
    input logic [(1<<ID_W)-1:0] done_map
);
    // R4: a pending bit only rises when its mask bit was clear
    assert_pend0_unmasked_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(pend[0]) |-> $past(!mask[0]));
    assert_pend1_unmasked_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(pend[1]) |-> $past(!mask[1]));

    // R3: a pending bit never stands without its raw source bit
    assert_pend_has_src_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (pend & ~src) == 2'b00);

    // R6: submit only rises after a bus write
    assert_submit_from_write_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(submit) |-> $past(wr_en));

    // R7: each accepted request steps the next ID by one
    assert_id_step_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (eng_accept && xfer_req) |=> next_id == ID_W'($past(next_id) + 1'b1));

    // R10: no completed source while cyclic
    assert_cyclic_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
        cyclic |=> !$rose(src[1]));

    // R11: disabled channel flushes submit and done bitmap
    assert_disable_flush_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !enable |=> (done_map == '0 && !submit));
endmodule

bind dqc_top dqc_checker #(.ID_W(ID_W)) u_dqc_checker (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .eng_accept(eng_accept),
    .xfer_req(xfer_req), .enable(ctl_enable), .submit(submit_q),
    .cyclic(ctl_cyclic), .mask(irq_mask_q), .pend(irq_pend_q),
    .src(irq_src_q), .next_id(next_id_q), .done_map(done_map_q)
);

// File: tb/dqc_top_test.sv
`timescale 1ns/100ps
module dqc_top_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [3:0]  wr_addr = '0;
    logic [31:0] wr_data = '0;
    logic [3:0]  rd_addr = '0;
    logic [31:0] rd_data;
    logic        eng_accept = 1'b0, eng_complete = 1'b0;
    logic        xfer_req, chan_enable, chan_pause, chan_cyclic, irq;
    logic [1:0]  xfer_id;

    int n_cmp = 0, n_bad = 0;

    always #2 clk = ~clk;

    dqc_top uut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data),
        .eng_accept(eng_accept), .eng_complete(eng_complete),
        .xfer_req(xfer_req), .xfer_id(xfer_id), .chan_enable(chan_enable),
        .chan_pause(chan_pause), .chan_cyclic(chan_cyclic), .irq(irq)
    );

    // Reference model state
    logic [1:0]  m_mask = 2'b11, m_pend = '0, m_src = '0;
    logic        m_en = 0, m_pause = 0, m_cyc = 0, m_sub = 0;
    logic [31:0] m_scr = '0;
    logic [1:0]  m_nxt = '0, m_act = '0;
    logic [3:0]  m_done = '0;
    int          m_outst = 0;

    task automatic check(input string tag, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
        end
    endtask

    function automatic logic [31:0] exp_read(input int a);
        case (a)
            0:  return 32'h444D4143;
            1:  return m_scr;
            4:  return {30'd0, m_mask};
            5:  return {30'd0, m_pend};
            6:  return {30'd0, m_src};
            8:  return {30'd0, m_pause, m_en};
            9:  return {30'd0, m_nxt};
            10: return {31'd0, m_sub};
            11: return {31'd0, m_cyc};
            12: return {28'd0, m_done};
            13: return {30'd0, m_act};
            default: return 32'd0;
        endcase
    endfunction

    function automatic string tag_of(input int a);
        case (a)
            0, 1:  return "R2";
            4, 5:  return "R4";
            6:     return "R3";
            8:     return "R11";
            9:     return "R7";
            10:    return "R6";
            11:    return "R10";
            12:    return "R9";
            13:    return "R8";
            default: return "R2";
        endcase
    endfunction

    function automatic logic exp_req();
        return m_sub && m_en && (m_outst < 4);
    endfunction

    task automatic read_check(input string tag, input int a);
        rd_addr = 4'(a);
        #0.1;
        check(tag, $sformatf("reg[%0d]", a), rd_data, exp_read(a));
    endtask

    task automatic compare_all();
        for (int a = 0; a < 16; a++) begin
            if (a == 2 || a == 7 || a == 15 || a < 14 || a == 14)
                read_check(tag_of(a), a);
        end
        check("R5", "irq", {31'd0, irq}, {31'd0, |m_pend});
        check("R6", "xfer_req", {31'd0, xfer_req}, {31'd0, exp_req()});
        check("R7", "xfer_id", {30'd0, xfer_id}, {30'd0, m_nxt});
        check("R11", "chan_enable", {31'd0, chan_enable}, {31'd0, m_en});
    endtask

    // Model update for one clock edge from old state and this cycle's inputs.
    task automatic model_edge(input bit we, input int a, input logic [31:0] d,
                              input bit acc, input bit cmp);
        bit qev, cev;
        logic [1:0] ev;
        qev = acc && exp_req();
        cev = cmp && m_en && (m_outst > 0) && !m_cyc;
        ev = {cev, qev};
        for (int k = 0; k < 2; k++) begin
            if (ev[k]) begin
                m_src[k] = 1'b1;
                if (!m_mask[k]) m_pend[k] = 1'b1;
                else if (we && a == 5 && d[k]) m_pend[k] = 1'b0;
            end else if (we && a == 5 && d[k]) begin
                m_src[k] = 1'b0;
                m_pend[k] = 1'b0;
            end
        end
        if (!m_en) begin
            m_sub = 0; m_done = '0; m_outst = 0; m_act = m_nxt;
        end else begin
            if (qev) begin
                m_done[m_nxt] = 1'b0; m_nxt = m_nxt + 2'd1; m_outst++; m_sub = 0;
            end else if (we && a == 10 && d[0]) m_sub = 1;
            if (cev) begin
                m_done[m_act] = 1'b1; m_act = m_act + 2'd1; m_outst--;
            end
        end
        if (we) begin
            case (a)
                1:  m_scr = d;
                4:  m_mask = d[1:0];
                8:  begin m_en = d[0]; m_pause = d[1]; end
                11: m_cyc = d[0];
                default: ;
            endcase
        end
    endtask

    task automatic step(input bit we, input int a, input logic [31:0] d,
                        input bit acc, input bit cmp);
        wr_en = we; wr_addr = 4'(a); wr_data = d;
        eng_accept = acc; eng_complete = cmp;
        @(posedge clk);
        model_edge(we, a, d, acc, cmp);
        #1;
        wr_en = 0; eng_accept = 0; eng_complete = 0;
        compare_all();
    endtask

    initial begin
        repeat (2000000) @(posedge clk);
        n_cmp++; n_bad++;
        $display("FAIL watchdog: actual hung expected finish");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        void'($urandom(32'd20250611));
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        #1;
        // R1: reset values
        for (int a = 0; a < 16; a++) read_check("R1", a);
        check("R1", "irq", {31'd0, irq}, 32'd0);
        check("R1", "xfer_req", {31'd0, xfer_req}, 32'd0);

        // R2: scratch and identification
        step(1, 1, 32'hA5C3_0F96, 0, 0);
        step(1, 0, 32'h1234_5678, 0, 0);
        step(1, 15, 32'hFFFF_FFFF, 0, 0);
        read_check("R2", 0);

        // R6: submit while disabled is ignored; pulses while idle ignored
        step(1, 10, 32'd1, 1, 1);
        read_check("R6", 10);

        // Enable, unmask queued only
        step(1, 8, 32'd1, 0, 0);
        step(1, 4, 32'd2, 0, 0);
        step(1, 10, 32'd0, 0, 0);
        read_check("R6", 10);
        step(1, 10, 32'd1, 0, 0);
        check("R6", "xfer_req after submit", {31'd0, xfer_req}, 32'd1);
        step(0, 0, 0, 1, 0);
        read_check("R7", 9);
        check("R5", "irq queued", {31'd0, irq}, 32'd1);

        // R12: fill to 4 outstanding, ID wraps
        for (int i = 0; i < 3; i++) begin
            step(1, 10, 32'd1, 0, 0);
            step(0, 0, 0, 1, 0);
        end
        read_check("R7", 9);
        step(1, 10, 32'd1, 0, 0);
        check("R12", "xfer_req full", {31'd0, xfer_req}, 32'd0);
        step(0, 0, 0, 1, 0);
        read_check("R12", 10);
        read_check("R12", 9);

        // R3/R4: clear collides with an event
        step(1, 4, 32'd0, 0, 0);
        step(1, 5, 32'd3, 0, 1);
        read_check("R4", 5);
        read_check("R3", 6);
        read_check("R9", 12);
        read_check("R8", 13);

        // R10: cyclic suppresses completion
        step(1, 5, 32'd3, 0, 0);
        step(1, 11, 32'd1, 0, 0);
        step(0, 0, 0, 0, 1);
        read_check("R10", 6);
        read_check("R10", 13);
        step(1, 11, 32'd0, 0, 0);

        // R11: disable with transfers outstanding
        step(1, 8, 32'd0, 0, 0);
        step(0, 0, 0, 0, 0);
        read_check("R11", 12);
        read_check("R11", 13);
        read_check("R11", 10);

        // Random mix
        step(1, 8, 32'd1, 0, 0);
        for (int i = 0; i < 4000; i++) begin
            int op;
            bit acc, cmp;
            op  = int'($urandom % 16);
            acc = ($urandom % 3) == 0;
            cmp = ($urandom % 4) == 0;
            case (op)
                0, 1, 2: step(0, 0, 0, acc, cmp);
                3:  step(1, 5, $urandom % 4, acc, cmp);
                4:  step(1, 4, $urandom % 4, acc, cmp);
                5:  step(1, 8, {30'd0, 1'($urandom % 2), 1'(($urandom % 8) != 0)}, acc, cmp);
                6, 7, 8: step(1, 10, {31'd0, 1'(($urandom % 5) != 0)}, acc, cmp);
                9:  step(1, 11, {31'd0, 1'(($urandom % 4) == 0)}, acc, cmp);
                10: step(1, 1, $urandom, acc, cmp);
                11: step(1, int'($urandom % 16), $urandom, acc, cmp);
                default: step(0, 0, 0, acc, cmp);
            endcase
            if (!m_en && ($urandom % 2) == 0) step(1, 8, 32'd1, 0, 0);
        end

        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule